// File: doc/BRIEF.md
# Banked Event-Sense Input Controller

This block watches a bank of 32 digital inputs for edge events and presents them to software through a byte-wide register window of eight ports. Each input passes through a two-flop synchroniser. A third flop keeps the previous sample, and comparing the two gives a rising or falling edge. A polarity register holds one bit for each group of four inputs and chooses which edge direction counts as an event for that group.

An event sets a sticky status bit. The status bit stays set until software writes a 1 to its position. The interrupt output goes high when any status bit is set and the global interrupt enable is on.

The eight ports reach one of three register banks:
- Bank 0 holds the synchronised input values, the polarity register and the enable.
- Bank 1 holds the event status bits and their clear.
- Bank 2 holds four placeholder debounce bytes.

Port 7 of every bank is the bank selector. Bank code 11 is reserved.

Top module: `evt_bank_ctrl`

## Requirements
- R1: After reset the bank is 0, every status bit is 0, the polarity register is 0x00, the enable is 0 and `irq` is 0.
- R2: In bank 0, a read of port k (k = 0..3) returns the synchronised inputs 8k+7..8k, with input 8k on bit 0. The value is visible no later than the third rising clock edge after the input changes.
- R3: In bank 0, port 4 is the polarity register. Bit n governs inputs 4n..4n+3: a 1 selects falling edges and a 0 selects rising edges. It reads back as written.
- R4: A qualifying edge sets the status bit of that input. In bank 1, a read of port k (k = 0..3) returns the status of inputs 8k+7..8k, with input 8k on bit 0. A status bit stays set while further edges of either direction arrive.
- R5: In bank 1, a write to port k (k = 0..3) clears each status bit whose data bit is 1. Status bits whose data bit is 0 keep their value.
- R6: In bank 0, bit 0 of port 5 is the interrupt enable, and it reads back with bits 7..1 as 0. `irq` equals the enable ANDed with the OR of all status bits.
- R7: A write to port 7 in any bank loads the bank from data bits 7:6 when they are 00, 01 or 10. A write with 11 in bits 7:6 leaves the bank unchanged.
- R8: A read of port 7 returns the current bank in bits 7:6 and 0 in bits 5:0. Ports with no register read 0: bank 0 port 6, bank 1 ports 4..6, and bank 2 ports 4..6.
- R9: In bank 2, ports 0..3 are read/write bytes that read back as written and have no effect on event detection.
- R10: A write reaches only the register that the current bank maps at that port. For example, a write to port 4 or port 5 while bank 1 is selected changes neither the polarity nor the enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| ev_in | input | 32 | Asynchronous event inputs |
| addr | input | 3 | Port number within the selected bank |
| wr_en | input | 1 | Write strobe, one cycle per write |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Read data for `addr` in the current bank (combinational) |
| irq | output | 1 | Interrupt request |

## Verification
The hardest case to reach is a status bit that has been set by an edge of the selected direction and then sees edges of the other direction, or a changed polarity, before software clears it. Only a long run of input changes with the polarity and clears interleaved shows that such a bit is neither lost nor set wrongly. The stimulus therefore mixes random input words with random polarity rewrites and random partial clears over many steps. A bench model updates the expected status from the old input, the new input and the polarity in force at each step.

// File: rtl/evt_bank_ctrl.sv
module evt_bank_ctrl #(
  parameter int N_IN = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [N_IN-1:0] ev_in,
  input  logic [2:0]      addr,
  input  logic            wr_en,
  input  logic [7:0]      wr_data,
  output logic [7:0]      rd_data,
  output logic            irq
);
  localparam int NBYTE = N_IN / 8;
  localparam int NGRP  = N_IN / 4;

  logic [N_IN-1:0] s1, s2, s3, st, clr, pol_x, evt;
  logic [NGRP-1:0] pol;
  logic [1:0]      bank;
  logic            ien;
  logic [7:0]      db [NBYTE];

  for (genvar i = 0; i < N_IN; i++) begin : g_pol
    assign pol_x[i] = pol[i/4];
  end

  assign evt = (pol_x & s3 & ~s2) | (~pol_x & s2 & ~s3);
  assign irq = ien & (|st);

  always_comb begin
    clr = '0;
    if (wr_en && bank == 2'd1 && int'(addr) < NBYTE)
      clr[int'(addr)*8 +: 8] = wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1 <= '0;
      s2 <= '0;
      s3 <= '0;
      st <= '0;
    end else begin
      s1 <= ev_in;
      s2 <= s1;
      s3 <= s2;
      st <= (st & ~clr) | evt;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bank <= 2'd0;
      pol  <= '0;
      ien  <= 1'b0;
      for (int k = 0; k < NBYTE; k++) db[k] <= 8'h00;
    end else if (wr_en) begin
      if (addr == 3'd7) begin
        if (wr_data[7:6] != 2'b11) bank <= wr_data[7:6];
      end else if (bank == 2'd0) begin
        if (addr == 3'd4) pol <= wr_data[NGRP-1:0];
        if (addr == 3'd5) ien <= wr_data[0];
      end else if (bank == 2'd2 && int'(addr) < NBYTE) begin
        db[addr[1:0]] <= wr_data;
      end
    end
  end

  always_comb begin
    rd_data = 8'h00;
    if (addr == 3'd7) rd_data = {bank, 6'b0};
    else if (int'(addr) < NBYTE) begin
      case (bank)
        2'd0:    rd_data = s2[int'(addr)*8 +: 8];
        2'd1:    rd_data = st[int'(addr)*8 +: 8];
        2'd2:    rd_data = db[addr[1:0]];
        default: rd_data = 8'h00;
      endcase
    end else if (bank == 2'd0 && addr == 3'd4) rd_data = pol;
    else if (bank == 2'd0 && addr == 3'd5) rd_data = {7'b0, ien};
  end
endmodule

// File: rtl/evt_bank_chk.sv
module evt_bank_chk #(
  parameter int N_IN = 32
) (
  input logic            clk,
  input logic            rst_n,
  input logic            wr_en,
  input logic [2:0]      addr,
  input logic [7:0]      wr_data,
  input logic            irq,
  input logic [1:0]      bank,
  input logic [N_IN-1:0] st,
  input logic            ien
);
  logic [N_IN-1:0] clr_w;

  always_comb begin
    clr_w = '0;
    if (wr_en && bank == 2'd1 && addr < 3'd4)
      clr_w[int'(addr)*8 +: 8] = wr_data;
  end

  p_bank_legal_r7: assert property (@(posedge clk) disable iff (!rst_n)
    bank != 2'b11);

  p_bad_bank_kept_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == 3'd7 && wr_data[7:6] == 2'b11) |=> $stable(bank));

  p_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((($past(st) & ~$past(clr_w)) & ~st) == '0));

  p_irq_pending_r6: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (ien && st != '0));

  p_irq_raised_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (ien && st != '0) |-> irq);

  p_bank_sel_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == 3'd7 && wr_data[7:6] != 2'b11) |=> bank == $past(wr_data[7:6]));
endmodule

bind evt_bank_ctrl evt_bank_chk #(.N_IN(N_IN)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wr_data(wr_data),
  .irq(irq), .bank(bank), .st(st), .ien(ien)
);

// File: tb/test_evt_bank_ctrl.sv
module test_evt_bank_ctrl;
  logic        clk = 0;
  logic        rst_n = 0;
  logic [31:0] ev_in = '0;
  logic [2:0]  addr = '0;
  logic        wr_en = 0;
  logic [7:0]  wr_data = '0;
  logic [7:0]  rd_data;
  logic        irq;

  int total = 0, bad = 0;
  logic [31:0] m_st, m_in;
  logic [7:0]  m_pol;
  logic        m_en;
  logic [7:0]  v;

  always #10 clk = ~clk;

  evt_bank_ctrl i_evt_bank_ctrl (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    addr = a; wr_data = d; wr_en = 1;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk);
    addr = a; wr_en = 0;
    #1 d = rd_data;
  endtask

  task automatic sel(input logic [1:0] b);
    wr(3'd7, {b, 6'b0});
  endtask

  function automatic logic [31:0] next_st(input logic [31:0] st, input logic [31:0] o,
                                          input logic [31:0] n, input logic [7:0] p);
    logic [31:0] r = st;
    for (int i = 0; i < 32; i++)
      if (p[i/4] ? (o[i] && !n[i]) : (!o[i] && n[i])) r[i] = 1'b1;
    return r;
  endfunction

  task automatic drive_in(input logic [31:0] n);
    @(negedge clk);
    m_st = next_st(m_st, m_in, n, m_pol);
    m_in = n;
    ev_in = n;
    repeat (4) @(negedge clk);
  endtask

  task automatic check_status(input string req);
    sel(2'd1);
    for (int k = 0; k < 4; k++) begin
      rd(3'(k), v);
      chk(req, {24'b0, v}, {24'b0, m_st[k*8 +: 8]});
    end
    chk("R6", {31'b0, irq}, {31'b0, m_en & (|m_st)});
  endtask

  initial begin
    #(20 * 150000);
    bad++; total++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed));
    m_st = 0; m_in = 0; m_pol = 0; m_en = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    rd(3'd7, v); chk("R1", {24'b0, v}, 32'h00);
    chk("R1", {31'b0, irq}, 0);
    rd(3'd4, v); chk("R1", {24'b0, v}, 0);
    rd(3'd5, v); chk("R1", {24'b0, v}, 0);
    check_status("R1");

    // R2 readback of synchronised inputs
    sel(2'd0);
    @(negedge clk); ev_in = 32'hA5C3_0F81; m_in = ev_in;
    m_st = next_st(m_st, 0, m_in, 0);
    repeat (3) @(posedge clk);
    for (int k = 0; k < 4; k++) begin
      rd(3'(k), v); chk("R2", {24'b0, v}, {24'b0, m_in[k*8 +: 8]});
    end
    check_status("R4");

    // R5 clear bits selectively
    wr(3'd0, 8'h0F); m_st[7:0] &= ~8'h0F;
    wr(3'd2, 8'hFF); m_st[23:16] = 0;
    check_status("R5");

    // R7/R8 bank select and invalid code
    sel(2'd2);
    wr(3'd7, 8'hFF);
    rd(3'd7, v); chk("R7", {24'b0, v}, 32'h80);
    rd(3'd5, v); chk("R8", {24'b0, v}, 0);
    // R9 placeholder bytes
    wr(3'd1, 8'h5A); wr(3'd3, 8'hC6);
    rd(3'd1, v); chk("R9", {24'b0, v}, 32'h5A);
    rd(3'd3, v); chk("R9", {24'b0, v}, 32'hC6);
    sel(2'd1);
    rd(3'd7, v); chk("R8", {24'b0, v}, 32'h40);
    rd(3'd6, v); chk("R8", {24'b0, v}, 0);
    // R10 writes to unmapped ports in bank 1
    wr(3'd4, 8'hFF); wr(3'd5, 8'h01);
    sel(2'd0);
    rd(3'd4, v); chk("R10", {24'b0, v}, 0);
    rd(3'd5, v); chk("R10", {24'b0, v}, 0);
    rd(3'd6, v); chk("R8", {24'b0, v}, 0);

    // R3 polarity and R6 enable
    m_pol = 8'h0F; wr(3'd4, m_pol);
    rd(3'd4, v); chk("R3", {24'b0, v}, 32'h0F);
    m_en = 1; wr(3'd5, 8'hFF);
    rd(3'd5, v); chk("R6", {24'b0, v}, 32'h01);
    sel(2'd1);
    wr(3'd0, 8'hFF); wr(3'd1, 8'hFF); wr(3'd2, 8'hFF); wr(3'd3, 8'hFF);
    m_st = 0;
    check_status("R6");
    drive_in(32'h0000_0000);
    check_status("R3");
    drive_in(32'hFFFF_FFFF);
    check_status("R3");

    // random mix
    for (int it = 0; it < 60; it++) begin
      if ($urandom_range(0, 3) == 0) begin
        sel(2'd0);
        m_pol = 8'($urandom); wr(3'd4, m_pol);
        m_en = 1'($urandom); wr(3'd5, {7'b0, m_en});
      end
      drive_in($urandom);
      check_status("R4");
      if ($urandom_range(0, 1) == 1) begin
        int k = $urandom_range(0, 3);
        logic [7:0] msk = 8'($urandom);
        wr(3'(k), msk);
        m_st[k*8 +: 8] &= ~msk;
        check_status("R5");
      end
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule